// File: doc/BRIEF.md
# Direct-Page Addressing Cycle Sequencer

This block generates the bus-cycle sequence an 8/16-bit processor core runs for its direct-page family of addressing modes. It also covers implied single-byte instructions and the immediate status set/clear instructions. A start pulse latches a mode code, an access kind (read or read-modify-write) and a width flag. The block then emits one cycle code per clock until the sequence is finished.

Each addressing mode has its own order of operand fetch, address-construction step, internal dummy program-counter reads and pointer fetches. A data phase follows, shaped by the width and the access kind. The core's datapath carries out each code: register arithmetic, the actual memory transfers and the operation itself stay outside this block. Alongside each code the block reports the step index and the operand byte count of the instruction. It returns to idle with a one-clock completion pulse.

Top module: `dp_cycle_seq`

## Requirements
- R1: After an asynchronous reset (rst_ni low), and during it, the block is idle: busy_o=0, cyc_o=0, step_o=0, done_o=0, opnd_bytes_o=0. A reset in the middle of a sequence aborts it at once.
- R2: While idle, a high start_i is accepted at the clock edge. From the next cycle busy_o=1 and step_o=0, and step_o then rises by one each clock. Cycle code encoding: 0 none (idle), 1 program-counter fetch with increment, 2 dummy program-counter read, 3 data fetch with increment, 4 data fetch without increment, 5 address-construction step, 6 internal modify, 7 write then decrement, 8 write, 9 perform operation. A busy sequence never shows code 0.
- R3: Mode 0 (direct) runs its address phase as 1, 5, 2: operand fetch, address construction, one dummy read.
- R4: Modes 1 and 2 (direct indexed by X, by Y) run their address phase as 1, 5, 2, 2.
- R5: Mode 3 (direct indirect) runs its address phase as 1, 5, 2, 3, 4, 5. Mode 4 (direct indexed indirect) runs it as 1, 5, 2, 2, 3, 4, 5. The pointer low byte comes with increment, then the pointer high byte, then the final address is built.
- R6: Mode 5 (stack relative) runs its address phase as 1, 2, 5: the dummy read comes before address construction.
- R7: Mode 6 (implied) runs 2, 9. Mode 7 (implied, long: byte swap, stop, wait) runs 2, 2, 9. Mode 8 (immediate status set/clear) runs 1, 2, 9. Codes 9 to 15 behave as mode 6. Modes 6 to 15 have no data phase, whatever rmw_i and wide_i are.
- R8: For modes 0 to 5, a read (rmw_i=0) adds the data phase 4 when wide_i=0, or 3, 4 (low then high) when wide_i=1.
- R9: For modes 0 to 5, a read-modify-write (rmw_i=1) adds the read cycles of R8, then 6, then 8 for 8-bit or 7, 8 (high then low) for 16-bit.
- R10: In the cycle after the last step, busy_o=0 and done_o=1 for exactly one clock. start_i, mode_i, rmw_i and wide_i have no effect while busy; a start seen while busy is dropped, not queued. A start in the done cycle is accepted.
- R11: While busy, opnd_bytes_o is 1 for modes 0 to 5 and 8 and 0 for all other modes; it is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sequence (accepted only while idle) |
| mode_i | input | 4 | Addressing mode code |
| rmw_i | input | 1 | 1: read-modify-write, 0: read |
| wide_i | input | 1 | 1: 16-bit data, 0: 8-bit data |
| busy_o | output | 1 | Sequence in progress |
| cyc_o | output | 4 | Cycle code for the current step |
| step_o | output | STEP_W | Step index within the sequence |
| done_o | output | 1 | One-clock pulse after the last step |
| opnd_bytes_o | output | 2 | Operand bytes of the running instruction |

## Verification
The bench builds the block with its default STEP_W of 4. The longest sequence, indexed indirect read-modify-write at 16 bits, uses twelve steps, so the step index comes close to the top of its range. Every mode, width and access kind is reached through the vector table. Directed runs cover a start dropped mid-sequence, a start held through the done cycle, reserved mode codes, and a reset that cuts a sequence short.

// File: rtl/dp_seq_pkg.sv
package dp_seq_pkg;
  typedef enum logic [3:0] {
    CYC_NONE      = 4'd0,
    CYC_PC_INC    = 4'd1,
    CYC_PC_DUMMY  = 4'd2,
    CYC_DATA_INC  = 4'd3,
    CYC_DATA      = 4'd4,
    CYC_ADDR      = 4'd5,
    CYC_MODIFY    = 4'd6,
    CYC_WRITE_DEC = 4'd7,
    CYC_WRITE     = 4'd8,
    CYC_OP        = 4'd9
  } cyc_e;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] M_DIR       = 4'd0;
  localparam logic [MODE_W-1:0] M_DIR_X     = 4'd1;
  localparam logic [MODE_W-1:0] M_DIR_Y     = 4'd2;
  localparam logic [MODE_W-1:0] M_DIR_IND   = 4'd3;
  localparam logic [MODE_W-1:0] M_DIR_X_IND = 4'd4;
  localparam logic [MODE_W-1:0] M_STK_REL   = 4'd5;
  localparam logic [MODE_W-1:0] M_IMPL      = 4'd6;
  localparam logic [MODE_W-1:0] M_IMPL_LONG = 4'd7;
  localparam logic [MODE_W-1:0] M_STAT_IMM  = 4'd8;
endpackage

// File: rtl/dp_addr_phase.sv
module dp_addr_phase
  import dp_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SLOTS = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output cyc_e              code_o,
  output logic [IDX_W-1:0]  len_o,
  output logic              has_data_o,
  output logic [1:0]        opnd_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  cyc_e seq [SLOTS];
  int   n;
  logic two_dummy, indirect, dp_mode;

  always_comb begin
    two_dummy = (mode_i == M_DIR_X) || (mode_i == M_DIR_Y) || (mode_i == M_DIR_X_IND);
    indirect  = (mode_i == M_DIR_IND) || (mode_i == M_DIR_X_IND);
    dp_mode   = (mode_i == M_DIR) || two_dummy || indirect;
    for (int i = 0; i < SLOTS; i++) seq[i] = CYC_NONE;
    n = 0;
    if (dp_mode) begin
      seq[0] = CYC_PC_INC;
      seq[1] = CYC_ADDR;
      seq[2] = CYC_PC_DUMMY;
      n = 3;
      if (two_dummy) begin
        seq[3] = CYC_PC_DUMMY;
        n = 4;
      end
      if (indirect) begin
        // pointer low, pointer high, then final address
        seq[n]   = CYC_DATA_INC;
        seq[n+1] = CYC_DATA;
        seq[n+2] = CYC_ADDR;
        n = n + 3;
      end
    end else if (mode_i == M_STK_REL) begin
      seq[0] = CYC_PC_INC;
      seq[1] = CYC_PC_DUMMY;
      seq[2] = CYC_ADDR;
      n = 3;
    end else if (mode_i == M_IMPL_LONG) begin
      seq[0] = CYC_PC_DUMMY;
      seq[1] = CYC_PC_DUMMY;
      seq[2] = CYC_OP;
      n = 3;
    end else if (mode_i == M_STAT_IMM) begin
      seq[0] = CYC_PC_INC;
      seq[1] = CYC_PC_DUMMY;
      seq[2] = CYC_OP;
      n = 3;
    end else begin
      seq[0] = CYC_PC_DUMMY;
      seq[1] = CYC_OP;
      n = 2;
    end
  end

  assign len_o      = IDX_W'(n);
  assign has_data_o = dp_mode || (mode_i == M_STK_REL);
  assign opnd_o     = (has_data_o || (mode_i == M_STAT_IMM)) ? 2'd1 : 2'd0;
  assign code_o     = (idx_i < IDX_W'(SLOTS)) ? seq[idx_i[SLOT_W-1:0]] : CYC_NONE;
endmodule

// File: rtl/dp_data_phase.sv
module dp_data_phase
  import dp_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SLOTS = 8
) (
  input  logic             rmw_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  output cyc_e             code_o,
  output logic [IDX_W-1:0] len_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  cyc_e seq [SLOTS];
  int   n;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) seq[i] = CYC_NONE;
    if (wide_i) begin
      seq[0] = CYC_DATA_INC;
      seq[1] = CYC_DATA;
      n = 2;
    end else begin
      seq[0] = CYC_DATA;
      n = 1;
    end
    if (rmw_i) begin
      seq[n] = CYC_MODIFY;
      // write-back runs high byte first
      if (wide_i) begin
        seq[n+1] = CYC_WRITE_DEC;
        seq[n+2] = CYC_WRITE;
        n = n + 3;
      end else begin
        seq[n+1] = CYC_WRITE;
        n = n + 2;
      end
    end
  end

  assign len_o  = IDX_W'(n);
  assign code_o = (idx_i < IDX_W'(SLOTS)) ? seq[idx_i[SLOT_W-1:0]] : CYC_NONE;
endmodule

// File: rtl/dp_cycle_seq.sv
module dp_cycle_seq
  import dp_seq_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic              rmw_i,
  input  logic              wide_i,
  output logic              busy_o,
  output logic [3:0]        cyc_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic [1:0]        opnd_bytes_o
);
  localparam int ADDR_SLOTS = 8;
  localparam int DATA_SLOTS = 8;

  logic              busy_q, done_q, rmw_q, wide_q;
  logic [STEP_W-1:0] step_q;
  logic [MODE_W-1:0] mode_q;

  cyc_e              a_code, d_code;
  logic [STEP_W-1:0] a_len, d_len, total, d_idx;
  logic              has_data, last;
  logic [1:0]        a_opnd;

  dp_addr_phase #(.IDX_W(STEP_W), .SLOTS(ADDR_SLOTS)) u_addr (
    .mode_i     (mode_q),
    .idx_i      (step_q),
    .code_o     (a_code),
    .len_o      (a_len),
    .has_data_o (has_data),
    .opnd_o     (a_opnd)
  );

  assign d_idx = step_q - a_len;

  dp_data_phase #(.IDX_W(STEP_W), .SLOTS(DATA_SLOTS)) u_data (
    .rmw_i  (rmw_q),
    .wide_i (wide_q),
    .idx_i  (d_idx),
    .code_o (d_code),
    .len_o  (d_len)
  );

  assign total = a_len + (has_data ? d_len : '0);
  assign last  = (step_q == total - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      mode_q <= '0;
      rmw_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          mode_q <= mode_i;
          rmw_q  <= rmw_i;
          wide_q <= wide_i;
        end
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign step_o       = step_q;
  assign cyc_o        = !busy_q ? CYC_NONE : ((step_q < a_len) ? a_code : d_code);
  assign opnd_bytes_o = busy_q ? a_opnd : 2'd0;

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (busy_q && step_q == '0));
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> (busy_q && step_q == STEP_W'($past(step_q) + 1'b1)));
  assert_busy_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cyc_o != CYC_NONE));
  assert_first_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cyc_o == CYC_PC_INC || cyc_o == CYC_PC_DUMMY));
  assert_writeback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == CYC_MODIFY) |=> (cyc_o == CYC_WRITE_DEC || cyc_o == CYC_WRITE));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> $stable(mode_q) && $stable(rmw_q) && $stable(wide_q));
endmodule

// File: tb/dp_cycle_seq_bench.sv
`timescale 1ns/1ps
module dp_cycle_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic       rmw_i = 1'b0;
  logic       wide_i = 1'b0;
  logic       busy_o, done_o;
  logic [3:0] cyc_o, step_o;
  logic [1:0] opnd_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dp_cycle_seq u_dp_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .rmw_i(rmw_i), .wide_i(wide_i), .busy_o(busy_o), .cyc_o(cyc_o),
    .step_o(step_o), .done_o(done_o), .opnd_bytes_o(opnd_o)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic        rmw;
    logic        wide;
    logic [7:0]  len;
    logic [63:0] codes;   // step 0 in the low nibble
    logic [1:0]  opnd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 1'b0, 8'd4,  64'h4251,         2'd1, 8'd3},  // R3
    '{4'd0,  1'b0, 1'b1, 8'd5,  64'h43251,        2'd1, 8'd8},  // R8
    '{4'd1,  1'b0, 1'b0, 8'd5,  64'h42251,        2'd1, 8'd4},  // R4
    '{4'd2,  1'b1, 1'b0, 8'd7,  64'h8642251,      2'd1, 8'd9},  // R4, R9
    '{4'd3,  1'b0, 1'b1, 8'd8,  64'h43543251,     2'd1, 8'd5},  // R5
    '{4'd4,  1'b1, 1'b1, 8'd12, 64'h876435432251, 2'd1, 8'd5},  // R5, R9
    '{4'd5,  1'b1, 1'b1, 8'd8,  64'h87643521,     2'd1, 8'd6},  // R6
    '{4'd5,  1'b0, 1'b0, 8'd4,  64'h4521,         2'd1, 8'd6},  // R6
    '{4'd6,  1'b1, 1'b1, 8'd2,  64'h92,           2'd0, 8'd7},  // R7
    '{4'd7,  1'b1, 1'b0, 8'd3,  64'h922,          2'd0, 8'd7},  // R7
    '{4'd8,  1'b0, 1'b1, 8'd3,  64'h921,          2'd1, 8'd7},  // R7, R11
    '{4'd12, 1'b1, 1'b1, 8'd2,  64'h92,           2'd0, 8'd7}   // R7 reserved code
  };

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input int req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    mode_i = v.mode; rmw_i = v.rmw; wide_i = v.wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < int'(v.len); k++) begin
      chk_eq(int'(v.req), "cycle code", int'(cyc_o), int'(v.codes[k*4 +: 4]));
      chk_eq(2, "step index", int'(step_o), k);        // R2
      chk_eq(11, "operand bytes", int'(opnd_o), int'(v.opnd));  // R11
      @(negedge clk);
    end
    chk_eq(10, "busy after last", int'(busy_o), 0);    // R10
    chk_eq(10, "done after last", int'(done_o), 1);
    @(negedge clk);
    chk_eq(10, "done one clock", int'(done_o), 0);
    chk_eq(11, "idle operand bytes", int'(opnd_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk_eq(1, "busy in reset", int'(busy_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq(1, "busy", int'(busy_o), 0);
    chk_eq(1, "cyc", int'(cyc_o), 0);
    chk_eq(1, "step", int'(step_o), 0);
    chk_eq(1, "done", int'(done_o), 0);
    chk_eq(1, "opnd", int'(opnd_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: start and mode change while busy are dropped
    @(negedge clk);
    mode_i = 4'd0; rmw_i = 1'b0; wide_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk_eq(10, "seq code 0", int'(cyc_o), 1);
    @(negedge clk);
    chk_eq(10, "seq code 1", int'(cyc_o), 5);
    mode_i = 4'd6; rmw_i = 1'b1; wide_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk_eq(10, "seq code 2", int'(cyc_o), 2);
    @(negedge clk);
    chk_eq(10, "seq code 3", int'(cyc_o), 4);
    @(negedge clk);
    chk_eq(10, "done after ignored start", int'(done_o), 1);
    @(negedge clk);
    chk_eq(10, "no queued start", int'(busy_o), 0);
    chk_eq(10, "idle code", int'(cyc_o), 0);

    // R2, R10: start held through the done cycle restarts
    mode_i = 4'd6; rmw_i = 1'b0; wide_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    chk_eq(2, "b2b first code", int'(cyc_o), 2);
    @(negedge clk);
    chk_eq(2, "b2b op code", int'(cyc_o), 9);
    @(negedge clk);
    chk_eq(10, "b2b done", int'(done_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    chk_eq(2, "b2b restart busy", int'(busy_o), 1);
    chk_eq(2, "b2b restart step", int'(step_o), 0);
    chk_eq(10, "b2b done cleared", int'(done_o), 0);
    @(negedge clk);
    chk_eq(2, "b2b second op", int'(cyc_o), 9);
    @(negedge clk);
    @(negedge clk);
    chk_eq(2, "b2b idle", int'(busy_o), 0);

    // R1: reset in the middle of a sequence
    mode_i = 4'd4; rmw_i = 1'b1; wide_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_eq(1, "abort busy", int'(busy_o), 0);
    chk_eq(1, "abort cyc", int'(cyc_o), 0);
    chk_eq(1, "abort step", int'(step_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq(1, "post reset idle", int'(busy_o), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule